// File: doc/BRIEF.md
# Presettable Binary Up-Counter with Cascade Carry

This block is a synchronous binary up-counter whose width is set by a parameter (4 bits by default). On a rising clock edge it can take a preset word from a parallel input, advance by one, or keep its value. An active-low clear returns it to zero at once, without waiting for a clock edge. The control inputs are ranked: clear first, then load, then count, then hold.

A carry output lets several stages be chained into a wider counter. Each higher stage takes the carry of the stage below as its count enable, and all stages share one clock. The carry is high only in the cycle where this stage is about to roll over from all ones to zero. The stage above therefore advances on the same edge.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is 0, `value_o` is all zeros without waiting for a clock edge. Clear overrides load and count.
- R2: With `clr_n` at 1 and `ld_en` at 1, a rising edge copies `preset_i` into `value_o`, whatever `cnt_en` is.
- R3: With `clr_n` at 1, `ld_en` at 0 and `cnt_en` at 1, a rising edge raises `value_o` by exactly one.
- R4: With `clr_n` at 1 and both `ld_en` and `cnt_en` at 0, a rising edge leaves `value_o` unchanged.
- R5: Counting from all ones (15 at the default width) gives all zeros on the next edge.
- R6: `carry_o` is 1 exactly when `value_o` is all ones, `cnt_en` is 1 and `ld_en` is 0. It is 0 otherwise, including when a load is pending on an all-ones value.
- R7: Two stages chained through `carry_o`, with the upper stage's `cnt_en` tied to the lower stage's carry, count as one counter twice as wide. This holds across the carry boundary between the stages.
- R8: The width is a parameter `W` with a default of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_en | input | 1 | Parallel load request |
| cnt_en | input | 1 | Count enable |
| preset_i | input | W | Parallel preset word |
| value_o | output | W | Current count |
| carry_o | output | 1 | High when the next count wraps this stage |

## Verification
The bench targets four kinds of error.

- **Priority.** It drives load and count together. A design that ranked count above load would show the old value plus one instead of the preset.
- **Asynchronous clear.** It drops clear in the middle of a clock period and checks the output before any edge arrives. A synchronous clear would still show the old count there.
- **Wrap point.** It walks through the all-ones to zero transition. It also checks that the carry stays low while a load is pending, and that it falls when count is released. A carry decoded from the all-ones state alone would wrongly advance a chained upper stage.
- **Cascade.** It counts a two-stage chain across the carry boundary and checks the combined value. An off-by-one or a late carry would show up there as a skipped or doubled high-order step.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        CNT_OP_HOLD = 2'd0,
        CNT_OP_INC  = 2'd1,
        CNT_OP_LOAD = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic    ld_en,
    input  logic    cnt_en,
    output cnt_op_e op_o
);

    // Load outranks count; clear is handled by the register itself.
    always_comb begin
        if (ld_en) begin
            op_o = CNT_OP_LOAD;
        end else if (cnt_en) begin
            op_o = CNT_OP_INC;
        end else begin
            op_o = CNT_OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_incr.sv
module cnt_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] inc_o,
    output logic         all_ones_o
);

    logic [W:0] chain;

    assign chain[0] = 1'b1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign inc_o[b]     = val_i[b] ^ chain[b];
        assign chain[b + 1] = chain[b] & val_i[b];
    end

    // The chain survives to the top only when every bit is one.
    assign all_ones_o = chain[W];

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_en,
    input  logic         cnt_en,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] value_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] value;
    } cnt_state_t;

    cnt_state_t   st_d;
    cnt_state_t   st_q;
    cnt_op_e      op;
    logic [W-1:0] inc_val;
    logic         at_top;

    cnt_ctrl u_ctrl (
        .ld_en  (ld_en),
        .cnt_en (cnt_en),
        .op_o   (op)
    );

    cnt_incr #(.W(W)) u_incr (
        .val_i      (st_q.value),
        .inc_o      (inc_val),
        .all_ones_o (at_top)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            CNT_OP_LOAD: st_d.value = preset_i;
            CNT_OP_INC:  st_d.value = inc_val;
            default:     st_d.value = st_q.value;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;
    assign carry_o = at_top && (op == CNT_OP_INC);

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> (value_o == '0));

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!clr_n)
        ld_en |=> (value_o == $past(preset_i)));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!ld_en && cnt_en) |=> (value_o == $past(value_o) + 1'b1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!ld_en && !cnt_en) |=> $stable(value_o));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_o |=> (value_o == '0));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_o |-> (cnt_en && !ld_en && (&value_o)));

endmodule

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;

    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         ld_en = 1'b0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] preset_i = '0;
    logic [W-1:0] value_o;
    logic         carry_o;

    logic [W-1:0] hi_preset = '0;
    logic [W-1:0] hi_value;
    logic         hi_carry;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cascade_counter #(.W(W)) u0 (
        .clk      (clk),
        .clr_n    (clr_n),
        .ld_en    (ld_en),
        .cnt_en   (cnt_en),
        .preset_i (preset_i),
        .value_o  (value_o),
        .carry_o  (carry_o)
    );

    cascade_counter #(.W(W)) u_hi (
        .clk      (clk),
        .clr_n    (clr_n),
        .ld_en    (ld_en),
        .cnt_en   (carry_o),
        .preset_i (hi_preset),
        .value_o  (hi_value),
        .carry_o  (hi_carry)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        clr_n = 1'b0; ld_en = 1'b0; cnt_en = 1'b0;
        tick();
        chk("R1 reset value", value_o, 0);
        chk("R6 reset carry", carry_o, 0);
        clr_n = 1'b1;
        tick();
    endtask

    task automatic t_load();
        ld_en = 1'b1; cnt_en = 1'b0; preset_i = 4'd9;
        tick();
        chk("R2 load 9", value_o, 9);
        preset_i = 4'd3;
        tick();
        chk("R2 load 3", value_o, 3);
        ld_en = 1'b0;
    endtask

    task automatic t_priority();
        ld_en = 1'b1; cnt_en = 1'b1; preset_i = 4'd6;
        tick();
        chk("R2 load beats count", value_o, 6);
        ld_en = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic t_hold();
        cnt_en = 1'b0; ld_en = 1'b0; preset_i = 4'd1;
        tick(); tick();
        chk("R4 hold", value_o, 6);
    endtask

    task automatic t_count();
        int exp = 6;
        cnt_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick();
            exp = (exp + 1) & MAXV;
            chk("R3 increment", value_o, exp);
        end
        cnt_en = 1'b0;
    endtask

    task automatic t_wrap_carry();
        ld_en = 1'b1; preset_i = 4'd15; cnt_en = 1'b0;
        tick();
        chk("R2 load 15", value_o, 15);
        ld_en = 1'b0;
        #1;
        chk("R6 carry low without count", carry_o, 0);
        ld_en = 1'b1; cnt_en = 1'b1; preset_i = 4'd15;
        #1;
        chk("R6 carry low under load", carry_o, 0);
        ld_en = 1'b0;
        #1;
        chk("R6 carry high at top", carry_o, 1);
        tick();
        chk("R5 wrap to zero", value_o, 0);
        chk("R6 carry drops after wrap", carry_o, 0);
        cnt_en = 1'b0;
    endtask

    task automatic t_async_clear();
        ld_en = 1'b1; preset_i = 4'd12;
        tick();
        ld_en = 1'b0; cnt_en = 1'b1;
        #0.5;
        clr_n = 1'b0;
        #0.5;
        chk("R1 async clear mid-cycle", value_o, 0);
        ld_en = 1'b1; preset_i = 4'd5;
        tick();
        chk("R1 clear beats load and count", value_o, 0);
        clr_n = 1'b1; ld_en = 1'b0; cnt_en = 1'b0;
        tick();
        chk("R1 stays zero after release", value_o, 0);
    endtask

    task automatic t_cascade();
        int exp = 8'hFB;
        ld_en = 1'b1; preset_i = 4'hB; hi_preset = 4'hF;
        tick();
        chk("R7 cascade load", {hi_value, value_o}, exp);
        ld_en = 1'b0; cnt_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            tick();
            exp = (exp + 1) & 8'hFF;
            chk("R7 cascade count", {hi_value, value_o}, exp);
        end
        cnt_en = 1'b0;
        tick();
        chk("R7 cascade hold", {hi_value, value_o}, exp);
        chk("R8 default width", $bits(value_o), 4);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_load();
        t_priority();
        t_hold();
        t_count();
        t_wrap_carry();
        t_async_clear();
        t_cascade();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule